// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is the interval timer of a processor's system-control unit. A 32-bit up-counter advances by one on every single-cycle tick strobe. The tick comes from outside the block, so the count rate (nominally 100 MHz) is set by whatever produces the strobe. Next to the counter sits a 32-bit match register. When an increment makes the counter equal to the match register, the block latches a timer-pending flag. While that flag is set, it raises one of eight interrupt lines.

Software can load the counter and the match register through write strobes, and it reads both values back on dedicated outputs. Writing the match register is how software acknowledges the interrupt. Any such write clears the pending flag, even if the value written is the one already held. A freeze input stops the counter, but direct loads still work while it is frozen. A 3-bit select input chooses which of the eight interrupt lines carries the timer request.

Top module: `cnt_cmp_timer`

## Requirements
- R1: After reset, the counter reads 1, the match register reads 0, the pending flag is 0 and all interrupt lines are 0.
- R2: With freeze low and no counter write, a tick strobe raises the counter by exactly one at the next rising edge. With no tick, the counter keeps its value.
- R3: While freeze is high, tick strobes leave the counter unchanged.
- R4: A counter write loads the written value at the next edge. This holds whether freeze is high or low, and the write wins over a tick in the same cycle.
- R5: A match-register write loads the written value at the next edge.
- R6: The pending flag sets on the same edge at which a tick makes the counter equal to the match register. Loading the counter, or the match register, to a value equal to the other does not set it.
- R7: Once set, the pending flag stays set through further ticks until the match register is written.
- R8: A match-register write clears the pending flag at the next edge, even if the value is unchanged. The clear wins over a match in the same cycle.
- R9: The counter wraps from 0xFFFFFFFF to 0x00000000. A match value below the counter therefore fires after the wrap.
- R10: The interrupt vector is all zero when nothing is pending. When the flag is pending, exactly bit `irq_sel` is 1. The vector follows a change of `irq_sel` in the same cycle, without waiting for a clock edge.
- R11: No match is taken while freeze is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Single-cycle count strobe |
| cnt_freeze | input | 1 | Holds the counter and suppresses matches when high |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 32 | Counter write value |
| cmp_we | input | 1 | Match-register write strobe; also acknowledges the interrupt |
| cmp_wdata | input | 32 | Match-register write value |
| irq_sel | input | 3 | Index of the interrupt line used by the timer |
| cnt_q | output | 32 | Current counter value |
| cmp_q | output | 32 | Current match-register value |
| pending | output | 1 | Timer-pending flag |
| irq_vec | output | 8 | Interrupt lines, at most one high |

## Verification
Counter loads, increments, match-register loads and the setting or clearing of the pending flag are all due one rising edge after the cycle that carries the strobe. `irq_vec` is decoded from the flag and `irq_sel` without a register, so it changes in the same cycle as either of them. The bench drives inputs 1 ns after each edge and advances its reference model on the edge, from the inputs then applied. It compares every output 1 ns after that edge. After an `irq_sel` change it also compares the vector again before the next edge.

// File: rtl/cct_pkg.sv
package cct_pkg;

  // what the counter does on the coming edge
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_act_e;

  // priority: a software load beats a tick; a frozen counter never steps
  function automatic cnt_act_e pick_act(input logic we, input logic tick,
                                        input logic freeze);
    if (we)
      return ACT_LOAD;
    else if (tick && !freeze)
      return ACT_STEP;
    else
      return ACT_HOLD;
  endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
#(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         freeze,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_nxt,
  output logic         stepped
);

  localparam logic [W-1:0] ONE = W'(1);

  // modular increment: all-ones rolls over to zero
  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  cnt_act_e act;

  always_comb begin
    act = pick_act(we, tick, freeze);
    unique case (act)
      ACT_LOAD: count_nxt = wdata;
      ACT_STEP: count_nxt = bump(count_q);
      default:  count_nxt = count_q;
    endcase
  end

  assign stepped = (act == ACT_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= RST_VAL;
    else        count_q <= count_nxt;
  end

  // R2: an enabled tick raises the count by one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !freeze && !we) |=> (count_q == $past(count_q) + ONE));

  // R2: idle cycle keeps the value
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !we) |=> $stable(count_q));

  // R3: frozen counter ignores ticks
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !we) |=> $stable(count_q));

  // R4: a write loads the value regardless of tick or freeze
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (count_q == $past(wdata)));

  // R9: all-ones steps to zero
  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stepped && (count_q == '1)) |=> (count_q == '0));

endmodule

// File: rtl/cct_match.sv
module cct_match #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stepped,
  input  logic [W-1:0] count_nxt,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp_q,
  output logic         hit,
  output logic         pending
);

  // a match is an increment that lands exactly on the match value
  function automatic logic lands_on(input logic step, input logic [W-1:0] nxt,
                                    input logic [W-1:0] target);
    return step && (nxt == target);
  endfunction

  // an acknowledge in the same cycle suppresses the match
  assign hit = lands_on(stepped, count_nxt, cmp_q) && !cmp_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= RST_VAL;
    else if (cmp_we) cmp_q <= cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (cmp_we) pending <= 1'b0;
    else if (hit)    pending <= 1'b1;
  end

  // R5: match-register load
  assert_cmp_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> (cmp_q == $past(cmp_wdata)));

  // R6: a landing increment sets the flag on that edge
  assert_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending);

  // R6: without a stepped landing the flag cannot rise
  assert_only_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !stepped) |=> !pending);

  // R7: sticky until acknowledged
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !cmp_we) |=> pending);

  // R8: any match-register write acknowledges
  assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !pending);

endmodule

// File: rtl/cct_irq_route.sv
module cct_irq_route #(
  parameter int SEL_W = 3,
  localparam int LINES = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] vec
);

  function automatic logic [LINES-1:0] steer(input logic req,
                                             input logic [SEL_W-1:0] idx);
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++)
      v[i] = req && (idx == SEL_W'(i));
    return v;
  endfunction

  assign vec = steer(pending, sel);

  // R10: at most one line, and a line only while pending
  assert_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec) && ((vec != '0) == pending));

  // R10: the active line is the selected one
  assert_vec_pos_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> vec[sel]);

endmodule

// File: rtl/cnt_cmp_timer.sv
module cnt_cmp_timer #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 3,
  parameter logic [CNT_W-1:0] CNT_RST = CNT_W'(1),
  parameter logic [CNT_W-1:0] CMP_RST = '0,
  localparam int LINES = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_freeze,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [SEL_W-1:0] irq_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             pending,
  output logic [LINES-1:0] irq_vec
);

  // internal events brought out for the assertions
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_stepped;
  logic             match_hit;

  cct_counter #(.W(CNT_W), .RST_VAL(CNT_RST)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .freeze   (cnt_freeze),
    .we       (cnt_we),
    .wdata    (cnt_wdata),
    .count_q  (cnt_q),
    .count_nxt(cnt_nxt),
    .stepped  (cnt_stepped)
  );

  cct_match #(.W(CNT_W), .RST_VAL(CMP_RST)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .stepped  (cnt_stepped),
    .count_nxt(cnt_nxt),
    .cmp_we   (cmp_we),
    .cmp_wdata(cmp_wdata),
    .cmp_q    (cmp_q),
    .hit      (match_hit),
    .pending  (pending)
  );

  cct_irq_route #(.SEL_W(SEL_W)) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .pending(pending),
    .sel    (irq_sel),
    .vec    (irq_vec)
  );

  // R11: a frozen timer never raises the flag
  assert_no_match_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_freeze && !pending) |=> !pending);

  // R6: a hit is always the result of a landing increment
  assert_hit_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> (cnt_q == cmp_q));

endmodule

// File: tb/cnt_cmp_timer_tb.sv
module cnt_cmp_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cnt_freeze = 1'b0, cnt_we = 1'b0, cmp_we = 1'b0;
  logic [31:0] cnt_wdata = '0, cmp_wdata = '0;
  logic [2:0]  irq_sel = '0;
  logic [31:0] cnt_q, cmp_q;
  logic        pending;
  logic [7:0]  irq_vec;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference state
  longint unsigned m_cnt = 1, m_cmp = 0;
  bit m_pend = 0;

  always #2 clk = ~clk;

  cnt_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_freeze(cnt_freeze),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .irq_sel(irq_sel), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .pending(pending), .irq_vec(irq_vec)
  );

  function automatic logic [7:0] exp_vec();
    return m_pend ? (8'h01 << irq_sel) : 8'h00;
  endfunction

  task automatic chk(input string tag, input longint unsigned act,
                     input longint unsigned exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, cnt_q, m_cnt, "count");
    chk(tag, cmp_q, m_cmp, "match");
    chk(tag, pending, m_pend, "pending");
    chk(tag, irq_vec, exp_vec(), "irq_vec");
  endtask

  // advance the reference model from the inputs present at this edge
  task automatic model_edge();
    longint unsigned nxt;
    bit moved;
    moved = tick && !cnt_freeze && !cnt_we;
    if (cnt_we)     nxt = cnt_wdata;
    else if (moved) nxt = (m_cnt + 1) % 64'h1_0000_0000;
    else            nxt = m_cnt;
    if (cmp_we)                        m_pend = 0;
    else if (moved && (nxt == m_cmp))  m_pend = 1;
    if (cmp_we) m_cmp = cmp_wdata;
    m_cnt = nxt;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    check_all(tag);
    tick = 0; cnt_we = 0; cmp_we = 0;
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      cyc(tag);
    end
  endtask

  task automatic load_cnt(input logic [31:0] v, input string tag);
    cnt_we = 1; cnt_wdata = v;
    cyc(tag);
  endtask

  task automatic load_cmp(input logic [31:0] v, input string tag);
    cmp_we = 1; cmp_wdata = v;
    cyc(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    chk("R1", cnt_q, 1, "reset count");
    rst_n = 1;
    cyc("R1");

    // R2: ticks interleaved with idle cycles
    ticks(3, "R2");
    cyc("R2");
    cyc("R2");
    ticks(1, "R2");
    chk("R2", cnt_q, 5, "count after four ticks");

    // R11 / R3: freeze with match just ahead
    load_cmp(32'd7, "R5");
    cnt_freeze = 1;
    ticks(6, "R3");
    chk("R11", pending, 0, "no match while frozen");
    // R4: load during freeze, then load with a tick
    load_cnt(32'h100, "R4");
    chk("R4", cnt_q, 32'h100, "frozen load");
    cnt_freeze = 0;
    tick = 1; cnt_we = 1; cnt_wdata = 32'h200;
    cyc("R4");
    chk("R4", cnt_q, 32'h200, "load beats tick");

    // R6: load counter onto match value: no flag
    load_cmp(32'h300, "R5");
    load_cnt(32'h300, "R6");
    chk("R6", pending, 0, "load equal no match");
    // R6: landing increment
    load_cnt(32'h2FD, "R6");
    ticks(2, "R6");
    chk("R6", pending, 0, "before landing");
    ticks(1, "R6");
    chk("R6", pending, 1, "landing sets flag");
    // R7: sticky
    ticks(4, "R7");
    cyc("R7");
    chk("R7", pending, 1, "still pending");
    // R10: sweep selects without a clock edge
    for (int s = 0; s < 8; s++) begin
      irq_sel = 3'(s);
      #1;
      chk("R10", irq_vec, 8'h01 << s, "vector follows select");
    end
    // R8: same-value write acknowledges
    load_cmp(32'h300, "R8");
    chk("R8", pending, 0, "ack same value");
    chk("R10", irq_vec, 0, "vector clear");

    // R9: wrap and match behind count
    irq_sel = 3'd5;
    load_cmp(32'd1, "R9");
    load_cnt(32'hFFFF_FFFE, "R9");
    ticks(2, "R9");
    chk("R9", cnt_q, 0, "wrapped");
    chk("R9", pending, 0, "not yet");
    ticks(1, "R9");
    chk("R9", pending, 1, "after wrap");
    chk("R10", irq_vec, 8'h20, "line five");

    // R8: clear wins over simultaneous landing
    load_cmp(32'h50, "R8");
    load_cnt(32'h4F, "R8");
    tick = 1; cmp_we = 1; cmp_wdata = 32'h50;
    cyc("R8");
    chk("R8", pending, 0, "clear beats match");
    // landing again later is a fresh match
    load_cnt(32'h4F, "R6");
    ticks(1, "R6");
    chk("R6", pending, 1, "fresh match");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule